// File: doc/BRIEF.md
# Tone Follower Cycle Qualifier

This block debounces the per-cycle verdicts from a tone window detector. Each time the detector closes a measurement it pulses a strobe with a validity flag, which says whether that input cycle fell inside the accepted frequency window. The block turns that stream into a steady tone-present indication. It changes its mind only after a run of consecutive strobes that contradict the present indication, so isolated good cycles on a quiet line and brief holes in a real tone are both absorbed.

The block is a two-state machine. In QUIET (no tone) the output `tone_n` is 1 and `tone_qual` is 0. In TONE, `tone_n` is 0 and `tone_qual` is 1. A run counter counts strobes whose validity disagrees with the present state. A strobe that agrees clears the counter. The transition DECLARE (QUIET to TONE) fires on the strobe that brings the count of consecutive valid strobes to `RUN_LEN`. The transition WITHDRAW (TONE to QUIET) fires on the strobe that brings the count of consecutive invalid strobes to `RUN_LEN`. The counter clears on either transition. Clock cycles without a strobe leave both the state and the counter unchanged. `tone_qual` is the same state as `tone_n` with true polarity, provided for a downstream packet sequencer.

Top module: `tone_follower_qual`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters QUIET with a zero run count: after that edge `tone_n` = 1 and `tone_qual` = 0.
- R2: From QUIET, the DECLARE transition takes place at the edge of the 16th consecutive strobe with `cyc_valid` = 1. After that edge `tone_n` = 0.
- R3: In QUIET, a run of 1 to 15 valid strobes followed by a strobe with `cyc_valid` = 0 leaves `tone_n` at 1 and restarts the count, so a full further 16 valid strobes are needed to declare.
- R4: From TONE, the WITHDRAW transition takes place at the edge of the 16th consecutive strobe with `cyc_valid` = 0. After that edge `tone_n` = 1.
- R5: In TONE, a dropout of 1 to 15 invalid strobes followed by a valid strobe leaves `tone_n` at 0 and restarts the count.
- R6: On a clock edge with `cyc_stb` = 0, `cyc_valid` is ignored, and both the state and the run count hold. Gaps between strobes therefore neither break nor extend a run.
- R7: `tone_qual` is always the logical inverse of `tone_n`.
- R8: A reset applied in TONE with a partial dropout count returns the block to QUIET and discards that count. After reset, 15 valid strobes do not declare and the 16th does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-cycle pulse marking a new cycle verdict |
| cyc_valid | input | 1 | Verdict for the strobed cycle: 1 = in window |
| tone_n | output | 1 | Debounced tone indication, 0 = tone present |
| tone_qual | output | 1 | Qualified state, 1 = tone present |

## Verification
Directed runs of exactly 15 and 16 agreeing strobes, applied in both directions, separate a correct threshold from an off-by-one threshold. A run broken at 15 and then restarted shows whether the counter actually clears on an agreeing strobe. Runs padded with strobe-free cycles, during which `cyc_valid` toggles, show that gaps neither advance nor break a run. A reset placed inside a partial dropout shows that the count is discarded. Random runs of 1 to 24 strobes, with random gaps, are compared against a bench model that steps a state and a count.

// File: rtl/tfq_pkg.sv
package tfq_pkg;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_TONE  = 1'b1
    } tfq_state_t;

endpackage

// File: rtl/tfq_run_counter.sv
module tfq_run_counter #(
    parameter int RUN_LEN = 16,
    parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             disagree,
    output logic [CNT_W-1:0] cnt,
    output logic             run_hit
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    // Terminal strobe: the one that completes a disagreeing run
    always_comb begin
        run_hit = stb && disagree && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (stb) begin
            if (!disagree || run_hit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tfq_state_fsm.sv
module tfq_state_fsm
    import tfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_hit,
    output tfq_state_t state,
    output logic       tone_n,
    output logic       tone_qual
);

    tfq_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_QUIET: if (run_hit) state_nxt = ST_TONE;   // DECLARE
            ST_TONE:  if (run_hit) state_nxt = ST_QUIET;  // WITHDRAW
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_QUIET;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_QUIET: begin
                tone_n    = 1'b1;
                tone_qual = 1'b0;
            end
            ST_TONE: begin
                tone_n    = 1'b0;
                tone_qual = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tone_follower_qual.sv
module tone_follower_qual #(
    parameter int RUN_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_stb,
    input  logic cyc_valid,
    output logic tone_n,
    output logic tone_qual
);

    import tfq_pkg::*;

    localparam int CNT_W = $clog2(RUN_LEN + 1);

    tfq_state_t       state;
    logic [CNT_W-1:0] run_cnt;
    logic             run_hit;
    logic             disagree;

    // Verdict contradicts the present state
    always_comb begin
        disagree = (cyc_valid != tone_qual);
    end

    tfq_run_counter #(
        .RUN_LEN (RUN_LEN),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .stb      (cyc_stb),
        .disagree (disagree),
        .cnt      (run_cnt),
        .run_hit  (run_hit)
    );

    tfq_state_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run_hit   (run_hit),
        .state     (state),
        .tone_n    (tone_n),
        .tone_qual (tone_qual)
    );

endmodule

// File: rtl/tfq_checker.sv
module tfq_checker #(
    parameter int RUN_LEN = 16,
    parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_stb,
    input logic             cyc_valid,
    input logic             tone_n,
    input logic             tone_qual,
    input logic [CNT_W-1:0] run_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (tone_n && !tone_qual && run_cnt == '0));

    p_declare_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(tone_n)) |-> $past(cyc_stb && cyc_valid && run_cnt == LAST));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LAST);

    p_agree_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && (cyc_valid == !tone_n)) |=> (run_cnt == '0 && $stable(tone_n)));

    p_withdraw_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(tone_n)) |-> $past(cyc_stb && !cyc_valid && run_cnt == LAST));

    p_gap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cyc_stb |=> ($stable(tone_n) && $stable(run_cnt)));

    p_polarity_r7: assert property (@(posedge clk) disable iff (rst)
        tone_qual != tone_n);

endmodule

bind tone_follower_qual tfq_checker #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_stb   (cyc_stb),
    .cyc_valid (cyc_valid),
    .tone_n    (tone_n),
    .tone_qual (tone_qual),
    .run_cnt   (run_cnt)
);

// File: tb/tb_tone_follower_qual.sv
module tb_tone_follower_qual;

    localparam int RUN = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_stb = 1'b0;
    logic cyc_valid = 1'b0;
    logic tone_n;
    logic tone_qual;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model: 1 = tone present
    bit m_tone = 1'b0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    tone_follower_qual #(.RUN_LEN(RUN)) dut (
        .clk       (clk),
        .rst       (rst),
        .cyc_stb   (cyc_stb),
        .cyc_valid (cyc_valid),
        .tone_n    (tone_n),
        .tone_qual (tone_qual)
    );

    function automatic bit model_step(bit r, bit s, bit v);
        bit toggled = 1'b0;
        if (r) begin
            m_tone = 1'b0;
            m_cnt  = 0;
        end else if (s) begin
            if (v != m_tone) begin
                m_cnt++;
                if (m_cnt == RUN) begin
                    m_tone  = !m_tone;
                    m_cnt   = 0;
                    toggled = 1'b1;
                end
            end else begin
                m_cnt = 0;
            end
        end
        return toggled;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at negedge, let one edge pass, compare at the next negedge
    task automatic step(bit r, bit s, bit v, string tag);
        bit tg;
        rst = r; cyc_stb = s; cyc_valid = v;
        @(posedge clk);
        tg = model_step(r, s, v);
        @(negedge clk);
        if (tg) check(m_tone ? "R2" : "R4", tone_n, !m_tone);
        else    check(tag, tone_n, !m_tone);
        check("R7", tone_qual, ~tone_n);
    endtask

    task automatic run(int n, bit v, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, v, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, "R1");
        check("R1", tone_n, 1'b1);

        // R3: 15 valid then a break, then 15 more: no tone
        run(15, 1'b1, "R3");
        run(1, 1'b0, "R3");
        run(15, 1'b1, "R3");
        check("R3", tone_n, 1'b1);
        // R2: 16th consecutive valid strobe declares
        run(1, 1'b1, "R2");
        check("R2", tone_n, 1'b0);

        // R5: dropout of 15 ignored, count restarts
        run(15, 1'b0, "R5");
        run(1, 1'b1, "R5");
        run(15, 1'b0, "R5");
        check("R5", tone_n, 1'b0);
        // R4: 16th consecutive invalid strobe withdraws
        run(1, 1'b0, "R4");
        check("R4", tone_n, 1'b1);

        // R6: gaps with toggling valid neither break nor extend a run
        for (int i = 0; i < 15; i++) begin
            step(1'b0, 1'b1, 1'b1, "R6");
            step(1'b0, 1'b0, 1'b0, "R6");
            step(1'b0, 1'b0, 1'b1, "R6");
        end
        check("R6", tone_n, 1'b1);
        run(1, 1'b1, "R6");
        check("R6", tone_n, 1'b0);

        // R8: reset inside a partial dropout
        run(10, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, "R8");
        check("R8", tone_n, 1'b1);
        run(15, 1'b1, "R8");
        check("R8", tone_n, 1'b1);
        run(1, 1'b1, "R8");
        check("R8", tone_n, 1'b0);

        // Random runs of 1..24 strobes with random gaps
        for (int k = 0; k < 300; k++) begin
            bit v = $urandom_range(0, 1);
            int n = $urandom_range(1, 24);
            for (int i = 0; i < n; i++) begin
                bit s = ($urandom_range(0, 3) != 0);
                step(1'b0, s, s ? v : bit'($urandom_range(0, 1)),
                     s ? (m_tone ? "R5" : "R3") : "R6");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule